// File: doc/BRIEF.md
# Virtual-Lane Marker Lock, Deskew and Merge

This block sits behind a multi-lane receiver in which a single high-rate stream of 66-bit blocks has been dealt out, one block at a time, over a set of parallel lanes. Each physical input carries a 66-bit word with a valid strobe. Every lane has its own delay, so a lane may run several blocks ahead of or behind its neighbours. The lanes may also arrive on the wrong physical inputs. Every lane periodically carries a marker word that names its logical lane number, and that word never occurs in data.

Each lane tracker hunts for markers and confirms them at the expected period. It then reports which logical lane that input carries. When every lane is locked and the lane numbers form a clean one-to-one mapping, a deskew controller arms per-lane FIFOs. Each FIFO starts filling at its own next marker. Reading begins only when all FIFOs hold a marker at their head, and from then on all lanes are read together. Rows made of markers are discarded. Data rows are emitted one block per cycle, in logical lane order, as a single 66-bit stream.

If the spread of skews is too large for the FIFOs, or two inputs claim the same lane, the aligned flag stays low and nothing is emitted.

Top module: `vlmd_lane_deskew`

## Requirements
- R1: A marker word has bits [65:64] = 2'b10, bits [63:16] = 48'h5A3C96E10F78, bits [15:8] = logical lane number (below NUM_LANES) and bits [7:0] = the bitwise complement of that number. Data words use header 2'b01 and never match this pattern.
- R2: An input's `lane_lock` bit rises one cycle after it accepts a second marker with the same lane number exactly PERIOD valid words after the first. It is low before that second marker.
- R3: A locked input stays locked through three consecutive expected marker positions without a matching marker. It drops lock one cycle after the fourth such position.
- R4: Output blocks follow logical lane order 0,1,…,NUM_LANES-1 within every round, whatever physical inputs the lanes arrive on. The first block emitted after alignment belongs to logical lane 0.
- R5: With a skew spread of at most FIFO_DEPTH-3 words between lanes, the output reproduces the original aggregate block sequence with no block lost, repeated or reordered.
- R6: With a skew spread of FIFO_DEPTH words or more (and below PERIOD-FIFO_DEPTH), `aligned` never rises and `out_valid` stays low, while the lanes themselves still lock.
- R7: If two inputs carry the same lane number, `aligned` stays low and `out_valid` stays low.
- R8: Marker words are never emitted. A round of markers yields no output blocks.
- R9: `aligned` is high only after all lanes are locked, and it falls within two cycles after any lane loses lock. `out_valid` is low in every cycle that follows a cycle with `aligned` low.
- R10: After reset, `out_valid`, `aligned` and all `lane_lock` bits are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | NUM_LANES | Per-input word strobe |
| in_data | input | NUM_LANES*66 | Per-input 66-bit words, input p in bits [p*66 +: 66] |
| out_valid | output | 1 | Output block strobe |
| out_data | output | 66 | Merged output block |
| lane_lock | output | NUM_LANES | Per-input marker lock |
| aligned | output | 1 | All lanes deskewed and merging |

## Verification
`lane_lock` for an input changes one cycle after the word that completes or breaks its marker check. Each bench tick drives one word per lane followed by NUM_LANES-1 idle cycles, so lock and `aligned` are sampled at the last falling edge of the tick that carries the deciding word, which is several cycles after the register update. The merged stream starts some rounds after the last lane's marker and depends on FIFO occupancy, so its data is not checked at a fixed cycle. Instead a scoreboard queue of the aggregate blocks is compared in order against each `out_valid` block, after aligning once on the first emitted block. The suppression cases count `out_valid` pulses over whole periods.

// File: rtl/vlmd_pkg.sv
package vlmd_pkg;

  localparam int          BLK_W    = 66;
  localparam logic [47:0] MARK_TAG = 48'h5A3C_96E1_0F78;

  typedef enum logic [1:0] {LK_HUNT, LK_VERIFY, LK_LOCKED} lock_st_t;
  typedef enum logic [1:0] {DS_IDLE, DS_FILL, DS_RUN} dsk_st_t;

  function automatic logic is_marker(input logic [BLK_W-1:0] w);
    return (w[65:64] == 2'b10) && (w[63:16] == MARK_TAG) && (w[15:8] == ~w[7:0]);
  endfunction

  function automatic logic [BLK_W-1:0] make_marker(input logic [7:0] id);
    return {2'b10, MARK_TAG, id, ~id};
  endfunction

endpackage

// File: rtl/vlmd_lane_lock.sv
module vlmd_lane_lock
  import vlmd_pkg::*;
#(
  parameter int NUM_LANES  = 20,
  parameter int PERIOD     = 16384,
  parameter int MISS_LIMIT = 4,
  localparam int CW = $clog2(PERIOD),
  localparam int MW = $clog2(MISS_LIMIT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [BLK_W-1:0] in_data,
  output logic             locked_o,
  output logic [7:0]       id_o
);

  localparam logic [7:0] LANES8 = 8'(NUM_LANES);

  lock_st_t        st_q, st_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic [7:0]      id_q, id_d;
  logic [MW-1:0]   miss_q, miss_d;
  logic            mk, same, at_slot;

  assign mk      = in_valid && is_marker(in_data) && (in_data[15:8] < LANES8);
  assign same    = mk && (in_data[15:8] == id_q);
  assign at_slot = (cnt_q == CW'(PERIOD - 1));

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    id_d   = id_q;
    miss_d = miss_q;
    if (in_valid) begin
      case (st_q)
        LK_HUNT: begin
          if (mk) begin
            st_d  = LK_VERIFY;
            cnt_d = '0;
            id_d  = in_data[15:8];
          end
        end
        LK_VERIFY: begin
          if (at_slot) begin
            cnt_d = '0;
            if (same)    st_d = LK_LOCKED;
            else if (mk) id_d = in_data[15:8];
            else         st_d = LK_HUNT;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        LK_LOCKED: begin
          if (at_slot) begin
            cnt_d = '0;
            if (same) begin
              miss_d = '0;
            end else if (miss_q == MW'(MISS_LIMIT - 1)) begin
              miss_d = '0;
              st_d   = LK_HUNT;
            end else begin
              miss_d = miss_q + 1'b1;
            end
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        default: st_d = LK_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= LK_HUNT;
      cnt_q  <= '0;
      id_q   <= '0;
      miss_q <= '0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      id_q   <= id_d;
      miss_q <= miss_d;
    end
  end

  assign locked_o = (st_q == LK_LOCKED);
  assign id_o     = id_q;

  // R2: lock is only granted on the cycle after a matching marker word
  p_lock_on_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked_o) |-> $past(in_valid && is_marker(in_data) && (in_data[15:8] == id_o)));

  // R3: miss counter never reaches the limit while held
  p_miss_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    miss_q < MW'(MISS_LIMIT));

endmodule

// File: rtl/vlmd_lane_fifo.sv
module vlmd_lane_fifo #(
  parameter int DEPTH = 32,
  parameter int WIDTH = 67,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic             full,
  output logic             empty
);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW-1:0]    wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic             wr_ok, rd_ok;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full  = (cnt_q == CW'(DEPTH));
  assign empty = (cnt_q == '0);
  assign wr_ok = wr_en && !full && !clr;
  assign rd_ok = rd_en && !empty && !clr;

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (clr) begin
      wp_d  = '0;
      rp_d  = '0;
      cnt_d = '0;
    end else begin
      if (wr_ok) wp_d = bump(wp_q);
      if (rd_ok) rp_d = bump(rp_q);
      cnt_d = cnt_q + CW'(wr_ok) - CW'(rd_ok);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_ok) mem_q[wp_q] <= wr_data;
  end

  assign rd_data = mem_q[rp_q];

  p_fifo_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));

  // R6: a full FIFO that is neither read nor cleared stays full
  p_full_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !rd_en && !clr) |=> full);

endmodule

// File: rtl/vlmd_deskew_ctrl.sv
module vlmd_deskew_ctrl
  import vlmd_pkg::*;
#(
  parameter int NUM_LANES = 20,
  localparam int IW = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_LANES-1:0]    lane_lock,
  input  logic [NUM_LANES*8-1:0]  lane_id,
  input  logic [NUM_LANES-1:0]    in_valid,
  input  logic [NUM_LANES-1:0]    in_mark,
  input  logic [NUM_LANES-1:0]    fifo_full,
  input  logic [NUM_LANES-1:0]    fifo_empty,
  input  logic [NUM_LANES-1:0]    head_mark,
  input  logic                    ser_ready,
  output logic                    fifo_clr,
  output logic [NUM_LANES-1:0]    fifo_wr,
  output logic                    pop,
  output logic                    load,
  output logic                    aligned,
  output logic [NUM_LANES*IW-1:0] map_flat
);

  dsk_st_t              st_q, st_d;
  logic [NUM_LANES-1:0] start_q, start_d;
  logic [IW-1:0]        map_q [NUM_LANES];
  logic [IW-1:0]        map_d [NUM_LANES];
  logic [IW-1:0]        map_sel [NUM_LANES];
  logic [NUM_LANES-1:0] hit [NUM_LANES];
  logic                 map_ok, all_lock, mixed;

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_log
    for (genvar p = 0; p < NUM_LANES; p++) begin : g_phy
      assign hit[l][p] = (lane_id[p*8 +: 8] == 8'(l));
    end
    assign map_flat[l*IW +: IW] = map_q[l];
  end

  always_comb begin
    map_ok = 1'b1;
    for (int l = 0; l < NUM_LANES; l++) begin
      map_ok     = map_ok && $onehot(hit[l]);
      map_sel[l] = '0;
      for (int p = 0; p < NUM_LANES; p++) begin
        if (hit[l][p]) map_sel[l] = IW'(p);
      end
    end
  end

  assign all_lock = &lane_lock;
  assign mixed    = (|head_mark) && !(&head_mark);
  assign fifo_clr = (st_q == DS_IDLE);
  assign fifo_wr  = (st_q == DS_RUN)  ? in_valid :
                    (st_q == DS_FILL) ? (in_valid & (start_q | in_mark)) : '0;
  assign pop      = (st_q == DS_RUN) && !(|fifo_empty) && ser_ready;
  assign load     = pop && !(|head_mark);
  assign aligned  = (st_q == DS_RUN);

  always_comb begin
    st_d    = st_q;
    start_d = start_q;
    map_d   = map_q;
    case (st_q)
      DS_IDLE: begin
        start_d = '0;
        if (all_lock && map_ok) begin
          st_d  = DS_FILL;
          map_d = map_sel;
        end
      end
      DS_FILL: begin
        start_d = start_q | (in_valid & in_mark);
        if (!all_lock || (|fifo_full)) st_d = DS_IDLE;
        else if (&start_d)             st_d = DS_RUN;
      end
      DS_RUN: begin
        if (!all_lock || (|(fifo_full & fifo_wr)) || (pop && mixed)) st_d = DS_IDLE;
      end
      default: st_d = DS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= DS_IDLE;
      start_q <= '0;
      for (int l = 0; l < NUM_LANES; l++) map_q[l] <= '0;
    end else begin
      st_q    <= st_d;
      start_q <= start_d;
      for (int l = 0; l < NUM_LANES; l++) map_q[l] <= map_d[l];
    end
  end

  // R9: losing any lane lock ends alignment on the next cycle
  p_lock_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (aligned && !all_lock) |=> !aligned);

endmodule

// File: rtl/vlmd_merge.sv
module vlmd_merge
  import vlmd_pkg::*;
#(
  parameter int NUM_LANES = 20,
  localparam int IW = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       flush,
  input  logic                       load,
  input  logic [NUM_LANES*BLK_W-1:0] row_flat,
  input  logic [NUM_LANES*IW-1:0]    map_flat,
  output logic                       ready,
  output logic                       out_valid,
  output logic [BLK_W-1:0]           out_data
);

  logic [BLK_W-1:0] row_q [NUM_LANES];
  logic [IW-1:0]    map_a [NUM_LANES];
  logic [IW-1:0]    idx_q, idx_d;
  logic             busy_q, busy_d, last;

  for (genvar i = 0; i < NUM_LANES; i++) begin : g_map
    assign map_a[i] = map_flat[i*IW +: IW];
  end

  assign last  = (idx_q == IW'(NUM_LANES - 1));
  assign ready = !busy_q || last;

  always_comb begin
    busy_d = busy_q;
    idx_d  = idx_q;
    if (flush) begin
      busy_d = 1'b0;
      idx_d  = '0;
    end else if (load) begin
      busy_d = 1'b1;
      idx_d  = '0;
    end else if (busy_q) begin
      if (last) busy_d = 1'b0;
      else      idx_d  = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
    end else begin
      busy_q <= busy_d;
      idx_q  <= idx_d;
    end
  end

  always_ff @(posedge clk) begin
    if (load && !flush) begin
      for (int i = 0; i < NUM_LANES; i++) row_q[i] <= row_flat[i*BLK_W +: BLK_W];
    end
  end

  assign out_valid = busy_q;
  assign out_data  = row_q[map_a[idx_q]];

  // R4: every burst of output starts at logical lane 0
  p_round_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> (idx_q == '0));

endmodule

// File: rtl/vlmd_lane_deskew.sv
module vlmd_lane_deskew
  import vlmd_pkg::*;
#(
  parameter int NUM_LANES  = 20,
  parameter int PERIOD     = 16384,
  parameter int FIFO_DEPTH = 32,
  parameter int MISS_LIMIT = 4,
  localparam int IW = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_LANES-1:0]       in_valid,
  input  logic [NUM_LANES*BLK_W-1:0] in_data,
  output logic                       out_valid,
  output logic [BLK_W-1:0]           out_data,
  output logic [NUM_LANES-1:0]       lane_lock,
  output logic                       aligned
);

  logic [1:0]                 rst_sync_q;
  logic                       srst_n;
  logic [NUM_LANES*8-1:0]     lane_id;
  logic [NUM_LANES-1:0]       in_mark, fifo_full, fifo_empty, head_mark, fifo_wr;
  logic [NUM_LANES*BLK_W-1:0] row_flat;
  logic [NUM_LANES*IW-1:0]    map_flat;
  logic                       fifo_clr, pop, load, ser_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign srst_n = rst_sync_q[1];

  for (genvar p = 0; p < NUM_LANES; p++) begin : g_lane
    logic [BLK_W:0] rd_word;

    assign in_mark[p] = is_marker(in_data[p*BLK_W +: BLK_W]);

    vlmd_lane_lock #(
      .NUM_LANES (NUM_LANES),
      .PERIOD    (PERIOD),
      .MISS_LIMIT(MISS_LIMIT)
    ) u_lock (
      .clk     (clk),
      .rst_n   (srst_n),
      .in_valid(in_valid[p]),
      .in_data (in_data[p*BLK_W +: BLK_W]),
      .locked_o(lane_lock[p]),
      .id_o    (lane_id[p*8 +: 8])
    );

    vlmd_lane_fifo #(
      .DEPTH(FIFO_DEPTH),
      .WIDTH(BLK_W + 1)
    ) u_fifo (
      .clk    (clk),
      .rst_n  (srst_n),
      .clr    (fifo_clr),
      .wr_en  (fifo_wr[p]),
      .wr_data({in_mark[p], in_data[p*BLK_W +: BLK_W]}),
      .rd_en  (pop),
      .rd_data(rd_word),
      .full   (fifo_full[p]),
      .empty  (fifo_empty[p])
    );

    assign head_mark[p]                 = rd_word[BLK_W];
    assign row_flat[p*BLK_W +: BLK_W]   = rd_word[BLK_W-1:0];
  end

  vlmd_deskew_ctrl #(
    .NUM_LANES(NUM_LANES)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (srst_n),
    .lane_lock (lane_lock),
    .lane_id   (lane_id),
    .in_valid  (in_valid),
    .in_mark   (in_mark),
    .fifo_full (fifo_full),
    .fifo_empty(fifo_empty),
    .head_mark (head_mark),
    .ser_ready (ser_ready),
    .fifo_clr  (fifo_clr),
    .fifo_wr   (fifo_wr),
    .pop       (pop),
    .load      (load),
    .aligned   (aligned),
    .map_flat  (map_flat)
  );

  vlmd_merge #(
    .NUM_LANES(NUM_LANES)
  ) u_merge (
    .clk      (clk),
    .rst_n    (srst_n),
    .flush    (!aligned),
    .load     (load),
    .row_flat (row_flat),
    .map_flat (map_flat),
    .ready    (ser_ready),
    .out_valid(out_valid),
    .out_data (out_data)
  );

  // R9: no output block follows a cycle without alignment
  p_no_out_unaligned_r9: assert property (@(posedge clk) disable iff (!srst_n)
    !aligned |=> !out_valid);

  // R8: marker words never reach the output
  p_no_marker_out_r8: assert property (@(posedge clk) disable iff (!srst_n)
    out_valid |-> !is_marker(out_data));

endmodule

// File: tb/vlmd_lane_deskew_bench.sv
module vlmd_lane_deskew_bench;
  import vlmd_pkg::*;

  localparam int N = 4;
  localparam int P = 64;
  localparam int D = 8;

  logic             clk;
  logic             rst_n;
  logic [N-1:0]     in_valid;
  logic [N*66-1:0]  in_data;
  logic             out_valid;
  logic [65:0]      out_data;
  logic [N-1:0]     lane_lock;
  logic             aligned;

  vlmd_lane_deskew #(
    .NUM_LANES(N), .PERIOD(P), .FIFO_DEPTH(D), .MISS_LIMIT(4)
  ) u_vlmd_lane_deskew (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data), .lane_lock(lane_lock), .aligned(aligned)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int          total = 0;
  int          bad   = 0;
  bit          done  = 0;
  int          perm [N];
  int          skew [N];
  int          corrupt_lane = -1;
  int          corrupt_from = 0;
  int          wt = 0;
  int          out_cnt = 0;
  bit          synced = 0;
  logic [65:0] sbq [$];

  function automatic logic [65:0] blk(input int k);
    return {2'b01, 32'hC0DE_0000, 32'(k)};
  endfunction

  function automatic logic [65:0] word_of(input int l, input int w);
    if (w < 0) return {2'b01, 64'hFFFF_FFFF_FFFF_FFFF};
    if (w % P == 0) return make_marker(8'(l));
    return blk((w - w / P - 1) * N + l);
  endfunction

  task automatic chk(input bit ok, input string msg);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s", msg);
    end
  endtask

  task automatic run_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      for (int p = 0; p < N; p++) begin
        int w;
        logic [65:0] v;
        w = wt - skew[p];
        v = word_of(perm[p], w);
        if (p == corrupt_lane && w >= corrupt_from && w % P == 0)
          v = {2'b01, 64'hEEEE_EEEE_EEEE_EEEE};
        in_data[p*66 +: 66] = v;
      end
      in_valid = '1;
      for (int l = 0; l < N; l++)
        if (wt % P != 0) sbq.push_back(blk((wt - wt / P - 1) * N + l));
      wt++;
      @(negedge clk);
      in_valid = '0;
      repeat (N - 1) @(negedge clk);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    in_valid = '0;
    in_data = '0;
    sbq.delete();
    synced = 0;
    wt = 0;
    out_cnt = 0;
    corrupt_lane = -1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      out_cnt++;
      if (!synced) begin
        while (sbq.size() > 0 && sbq[0] != out_data) void'(sbq.pop_front());
        synced = 1;
        chk(sbq.size() > 0 && (int'(out_data[31:0]) % N == 0),
            $sformatf("R4 first block not lane 0: act=%h exp=index multiple of %0d", out_data, N));
      end
      chk(out_data[65:64] == 2'b01,
          $sformatf("R8 output header act=%b exp=01", out_data[65:64]));
      if (sbq.size() == 0) begin
        chk(1'b0, $sformatf("R5 unexpected block act=%h exp=none", out_data));
      end else begin
        logic [65:0] e;
        e = sbq.pop_front();
        chk(out_data == e, $sformatf("R5 merged block act=%h exp=%h", out_data, e));
      end
    end
  end

  initial begin
    int c0;
    rst_n = 1'b0;
    in_valid = '0;
    in_data = '0;

    // scenario A: in order, small skew
    perm = '{0, 1, 2, 3};
    skew = '{0, 1, 2, 3};
    do_reset();
    chk(out_valid == 0 && aligned == 0 && lane_lock == '0,
        $sformatf("R10 reset act=%b/%b/%b exp=0/0/0000", out_valid, aligned, lane_lock));
    run_ticks(P);
    chk(lane_lock == 4'b0000, $sformatf("R2 before second marker act=%b exp=0000", lane_lock));
    run_ticks(1);
    chk(lane_lock == 4'b0001, $sformatf("R2 after second marker act=%b exp=0001", lane_lock));
    run_ticks(3);
    chk(lane_lock == 4'b1111, $sformatf("R1 all lanes locked act=%b exp=1111", lane_lock));
    run_ticks(5 * P);
    chk(aligned == 1'b1, $sformatf("R9 aligned act=%b exp=1", aligned));
    chk(out_cnt > 100, $sformatf("R5 output count act=%0d exp>100", out_cnt));

    // scenario B: reordered lanes, skew spread D-3
    perm = '{2, 0, 3, 1};
    skew = '{4, 0, 2, 5};
    do_reset();
    run_ticks(3 * P);
    chk(aligned == 1'b1, $sformatf("R4 aligned with reorder act=%b exp=1", aligned));
    chk(out_cnt > 50, $sformatf("R4 reordered output count act=%0d exp>50", out_cnt));
    corrupt_lane = 1;
    corrupt_from = 3 * P;
    run_ticks(3 * P);
    chk(lane_lock[1] == 1'b1, $sformatf("R3 after three misses act=%b exp=1", lane_lock[1]));
    run_ticks(1);
    chk(lane_lock[1] == 1'b0, $sformatf("R3 after fourth miss act=%b exp=0", lane_lock[1]));
    chk(aligned == 1'b0, $sformatf("R9 aligned after lock loss act=%b exp=0", aligned));
    c0 = out_cnt;
    run_ticks(P);
    chk(out_cnt == c0, $sformatf("R9 output while unaligned act=%0d exp=%0d", out_cnt, c0));

    // scenario C: skew spread beyond FIFO depth
    perm = '{0, 1, 2, 3};
    skew = '{0, 0, 0, 12};
    do_reset();
    run_ticks(6 * P);
    chk(lane_lock == 4'b1111, $sformatf("R6 lanes lock act=%b exp=1111", lane_lock));
    chk(aligned == 1'b0, $sformatf("R6 aligned act=%b exp=0", aligned));
    chk(out_cnt == 0, $sformatf("R6 outputs act=%0d exp=0", out_cnt));

    // scenario D: duplicate lane number
    perm = '{0, 1, 1, 3};
    skew = '{0, 0, 0, 0};
    do_reset();
    run_ticks(3 * P);
    chk(lane_lock == 4'b1111, $sformatf("R7 lanes lock act=%b exp=1111", lane_lock));
    chk(aligned == 1'b0, $sformatf("R7 aligned act=%b exp=0", aligned));
    chk(out_cnt == 0, $sformatf("R7 outputs act=%0d exp=0", out_cnt));

    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule